// File: doc/BRIEF.md
# Operand Bypass and Load-Dependency Stall Unit

This combinational unit sits beside the decode/register-read stage of a five-stage in-order pipeline. It looks at the 32-bit instruction being decoded and works out which two register numbers must be presented to the two read ports of the 16-entry register file. It then decides, for each read port, whether the value from the file is stale. If it is stale, it substitutes the newer result that is still travelling through the execute, memory-access or write-back stage.

When the instruction in the execute stage is a load whose destination is a register that the decoded instruction really consumes, the loaded word does not exist yet. In that case the unit raises a stall. The surrounding pipeline uses the stall to freeze the program counter and the fetch/decode buffer, and to push a no-operation (an add of register 0 to itself into register 0) into the decode/execute buffer for one cycle. Register 0 is hard-wired to zero: it is never bypassed and it never causes a stall.

Top module: `bypass_stall_unit`

## Requirements
- R1: Read port A always takes its register number from instruction bits [23:20]. Read port B takes bits [27:24] when the opcode in bits [31:28] is 4'b0100 (store word), and bits [3:0] for every other opcode. Both numbers appear on `rd_addr_a` and `rd_addr_b`.
- R2: When a stage has its write-valid flag set, its destination equals a nonzero port register number, and it is not a load sitting in execute, that stage's result replaces the register file value on the port's operand output.
- R3: A port whose register number is 0 outputs zero, whatever the register file or any stage presents. A destination of 0 never raises `stall`.
- R4: When several stages qualify under R2 for the same port, the execute result wins over the memory result, and the memory result wins over the write-back result.
- R5: A stage whose write-valid flag is clear is never used as a bypass source, even if its destination number matches.
- R6: A load in execute is never a bypass source. A matching memory-stage or write-back result is used instead if one exists, and otherwise the register file value.
- R7: `stall` is 1 when `ex_is_load` and `ex_wen` are both set, `ex_dst` is nonzero, and `ex_dst` equals a register that the opcode consumes. Port A is consumed by opcodes 0000 (add), 0001 (nand), 0010 (add immediate), 0011 (load), 0100 (store), 0110 (jump-and-link) and 1000 (skip). Port B is consumed by 0000, 0001, 0100 and 1000.
- R8: A match on a register field that the opcode does not consume never raises `stall`. Examples are port B of 0010 (add immediate) and 0011 (load), and any field of 0101 (goto), 0111 (halt) and 1001 (load address).
- R9: A nonzero port register matched by no qualifying stage outputs the register file value for that port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction held in the decode stage |
| rf_val_a | input | 32 | Register file read data for port A |
| rf_val_b | input | 32 | Register file read data for port B |
| ex_dst | input | 4 | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_val | input | 32 | Execute-stage result |
| mem_dst | input | 4 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_val | input | 32 | Memory-stage result (loaded word or passed-on value) |
| wb_dst | input | 4 | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_val | input | 32 | Write-back result |
| rd_addr_a | output | 4 | Register number driven to read port A |
| rd_addr_b | output | 4 | Register number driven to read port B |
| opnd_a | output | 32 | Bypassed operand for port A |
| opnd_b | output | 32 | Bypassed operand for port B |
| stall | output | 1 | Load dependency: freeze front end, insert a no-operation |

## Verification
Bypassing and the load-dependency stall can both be active in the same cycle. A load in execute can target one source while the other source, or the same source, matches an older result in memory or write-back. The bench sets this up with a load in execute writing port A's register, a memory-stage write to the same register and a write-back to port B's register. It then expects `stall` high while port A carries the memory value, not the execute value, and port B carries the write-back value. Cases where the load hits only an unconsumed field check that the stall stays low while the operand outputs are still correct.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int ILEN      = 32;
    localparam int OPC_W     = 4;
    localparam int OPC_LSB   = 28;
    localparam int FHI_LSB   = 24;
    localparam int FMID_LSB  = 20;
    localparam int FLO_LSB   = 0;
    localparam int FIELD_W   = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD   = 4'b0000,
        OPC_NAND  = 4'b0001,
        OPC_ADDI  = 4'b0010,
        OPC_LOAD  = 4'b0011,
        OPC_STORE = 4'b0100,
        OPC_GOTO  = 4'b0101,
        OPC_JLINK = 4'b0110,
        OPC_HALT  = 4'b0111,
        OPC_SKIP  = 4'b1000,
        OPC_LADDR = 4'b1001
    } opc_e;

    typedef struct packed {
        logic consume_a;
        logic consume_b;
        logic b_from_hi;
    } src_use_t;

    function automatic src_use_t decode_use(input logic [OPC_W-1:0] op);
        src_use_t u;
        u = '0;
        case (op)
            OPC_ADD, OPC_NAND, OPC_SKIP: begin
                u.consume_a = 1'b1;
                u.consume_b = 1'b1;
            end
            OPC_STORE: begin
                u.consume_a = 1'b1;
                u.consume_b = 1'b1;
                u.b_from_hi = 1'b1;
            end
            OPC_ADDI, OPC_LOAD, OPC_JLINK: u.consume_a = 1'b1;
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/bypass_src_decode.sv
module bypass_src_decode
    import bypass_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic [ILEN-1:0] instr,
    output logic [RW-1:0]   addr_a,
    output logic [RW-1:0]   addr_b,
    output logic            use_a,
    output logic            use_b
);
    src_use_t             u;
    logic [OPC_W-1:0]     op;
    logic [FIELD_W-1:0]   f_hi, f_mid, f_lo;
    logic                 unused_imm;

    assign op         = instr[OPC_LSB +: OPC_W];
    assign f_hi       = instr[FHI_LSB +: FIELD_W];
    assign f_mid      = instr[FMID_LSB +: FIELD_W];
    assign f_lo       = instr[FLO_LSB +: FIELD_W];
    assign unused_imm = ^instr[FMID_LSB-1:FLO_LSB+FIELD_W];

    always_comb begin
        u      = decode_use(op);
        use_a  = u.consume_a;
        use_b  = u.consume_b;
        addr_a = RW'(f_mid);
        addr_b = u.b_from_hi ? RW'(f_hi) : RW'(f_lo);
    end

    // R1: the store opcode must steer port B to the high field
    always_comb begin
        p_store_b_field_r1: assert (op != OPC_STORE || addr_b == RW'(f_hi))
            else $error("R1 store port B field");
    end
endmodule

// File: rtl/bypass_operand_mux.sv
module bypass_operand_mux #(
    parameter int XLEN = 32,
    parameter int RW   = 4,
    parameter int NSTG = 3
) (
    input  logic [RW-1:0]              addr,
    input  logic [XLEN-1:0]            rf_val,
    input  logic [NSTG-1:0][RW-1:0]    stg_dst,
    input  logic [NSTG-1:0]            stg_wen,
    input  logic [NSTG-1:0]            stg_block,
    input  logic [NSTG-1:0][XLEN-1:0]  stg_val,
    output logic [XLEN-1:0]            opnd
);
    logic [NSTG-1:0] qual;

    // index 0 is the youngest producer
    genvar g;
    generate
        for (g = 0; g < NSTG; g++) begin : g_qual
            assign qual[g] = stg_wen[g] && !stg_block[g] && (stg_dst[g] == addr);
        end
    endgenerate

    always_comb begin
        opnd = rf_val;
        for (int i = NSTG - 1; i >= 0; i--) begin
            if (qual[i]) opnd = stg_val[i];
        end
        if (addr == '0) opnd = '0;
    end

    always_comb begin
        p_zero_reg_r3: assert (addr != '0 || opnd == '0)
            else $error("R3 register 0 operand not zero");
        p_youngest_wins_r4: assert (addr == '0 || !qual[0] || opnd == stg_val[0])
            else $error("R4 youngest producer not selected");
        p_no_source_r9: assert (addr == '0 || qual != '0 || opnd == rf_val)
            else $error("R9 file value not passed");
    end
endmodule

// File: rtl/bypass_loaduse_detect.sv
module bypass_loaduse_detect #(
    parameter int RW = 4
) (
    input  logic [RW-1:0] addr_a,
    input  logic [RW-1:0] addr_b,
    input  logic          use_a,
    input  logic          use_b,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    output logic          stall
);
    logic       pending;
    logic [1:0] hit;

    assign pending = ex_is_load & ex_wen & (|ex_dst);
    assign hit[0]  = use_a & (addr_a == ex_dst);
    assign hit[1]  = use_b & (addr_b == ex_dst);
    assign stall   = pending & (|hit);

    always_comb begin
        p_stall_needs_load_r7: assert (!stall || (ex_is_load && ex_wen))
            else $error("R7 stall without load");
        p_stall_not_zero_r3: assert (!stall || ex_dst != '0)
            else $error("R3 stall on register 0");
        p_stall_consumed_r8: assert (!stall || use_a || use_b)
            else $error("R8 stall with no consumed source");
    end
endmodule

// File: rtl/bypass_stall_unit.sv
module bypass_stall_unit
    import bypass_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 16,
    localparam int RW   = $clog2(NREGS),
    localparam int NSTG = 3
) (
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] rf_val_a,
    input  logic [XLEN-1:0] rf_val_b,
    input  logic [RW-1:0]   ex_dst,
    input  logic            ex_wen,
    input  logic            ex_is_load,
    input  logic [XLEN-1:0] ex_val,
    input  logic [RW-1:0]   mem_dst,
    input  logic            mem_wen,
    input  logic [XLEN-1:0] mem_val,
    input  logic [RW-1:0]   wb_dst,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_val,
    output logic [RW-1:0]   rd_addr_a,
    output logic [RW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic            stall
);
    logic                        use_a, use_b;
    logic [NSTG-1:0][RW-1:0]     stg_dst;
    logic [NSTG-1:0]             stg_wen;
    logic [NSTG-1:0]             stg_block;
    logic [NSTG-1:0][XLEN-1:0]   stg_val;
    logic [1:0][RW-1:0]          port_addr;
    logic [1:0][XLEN-1:0]        port_rf;
    logic [1:0][XLEN-1:0]        port_opnd;

    assign stg_dst   = {wb_dst, mem_dst, ex_dst};
    assign stg_wen   = {wb_wen, mem_wen, ex_wen};
    assign stg_block = {1'b0, 1'b0, ex_is_load};
    assign stg_val   = {wb_val, mem_val, ex_val};

    bypass_src_decode #(.RW(RW)) u_dec (
        .instr (instr),
        .addr_a(rd_addr_a),
        .addr_b(rd_addr_b),
        .use_a (use_a),
        .use_b (use_b)
    );

    assign port_addr = {rd_addr_b, rd_addr_a};
    assign port_rf   = {rf_val_b, rf_val_a};

    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_port
            bypass_operand_mux #(.XLEN(XLEN), .RW(RW), .NSTG(NSTG)) u_mux (
                .addr     (port_addr[p]),
                .rf_val   (port_rf[p]),
                .stg_dst  (stg_dst),
                .stg_wen  (stg_wen),
                .stg_block(stg_block),
                .stg_val  (stg_val),
                .opnd     (port_opnd[p])
            );
        end
    endgenerate

    assign opnd_a = port_opnd[0];
    assign opnd_b = port_opnd[1];

    bypass_loaduse_detect #(.RW(RW)) u_lu (
        .addr_a    (rd_addr_a),
        .addr_b    (rd_addr_b),
        .use_a     (use_a),
        .use_b     (use_b),
        .ex_dst    (ex_dst),
        .ex_wen    (ex_wen),
        .ex_is_load(ex_is_load),
        .stall     (stall)
    );

    // R6: a load in execute must not be the value seen on port A
    always_comb begin
        p_load_not_bypassed_r6: assert (!(ex_is_load && ex_wen && ex_dst == rd_addr_a
                                          && rd_addr_a != '0 && !(mem_wen && mem_dst == rd_addr_a)
                                          && !(wb_wen && wb_dst == rd_addr_a))
                                        || opnd_a == rf_val_a)
            else $error("R6 load bypassed from execute");
    end
endmodule

// File: tb/bypass_stall_unit_test.sv
module bypass_stall_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr;
    logic [31:0] rf_val_a, rf_val_b, ex_val, mem_val, wb_val;
    logic [3:0]  ex_dst, mem_dst, wb_dst;
    logic        ex_wen, ex_is_load, mem_wen, wb_wen;
    logic [3:0]  rd_addr_a, rd_addr_b;
    logic [31:0] opnd_a, opnd_b;
    logic        stall;

    always #10 clk = ~clk;

    bypass_stall_unit uut (
        .instr(instr), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_val(ex_val),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_val(mem_val),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_val(wb_val),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall)
    );

    typedef struct {
        string       tag;
        logic [31:0] a;
        logic [31:0] b;
        logic        s;
        logic [3:0]  aa;
        logic [3:0]  ab;
    } exp_t;

    exp_t q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;
    bit   summed = 1'b0;

    localparam logic [31:0] FA = 32'h0000_0A0A;
    localparam logic [31:0] FB = 32'h0000_0B0B;

    function automatic logic [31:0] mk(logic [3:0] op, logic [3:0] hi, logic [3:0] mid, logic [3:0] lo);
        return {op, hi, mid, 16'h0000, lo};
    endfunction

    task automatic quiet();
        ex_dst = 0; ex_wen = 0; ex_is_load = 0; ex_val = 32'hE0E0_0001;
        mem_dst = 0; mem_wen = 0; mem_val = 32'h3E30_0002;
        wb_dst = 0; wb_wen = 0; wb_val = 32'h7B70_0003;
        rf_val_a = FA; rf_val_b = FB;
    endtask

    task automatic expect_out(string tag, logic [31:0] a, logic [31:0] b, logic s,
                              logic [3:0] aa, logic [3:0] ab);
        exp_t e;
        e.tag = tag; e.a = a; e.b = b; e.s = s; e.aa = aa; e.ab = ab;
        @(negedge clk);
        q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // monitor: pops one expectation per rising edge, inputs were settled at the falling edge
    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (opnd_a !== e.a) begin
                n_bad++; $display("FAIL %s opnd_a got %h exp %h", e.tag, opnd_a, e.a);
            end
            if (opnd_b !== e.b) begin
                n_bad++; $display("FAIL %s opnd_b got %h exp %h", e.tag, opnd_b, e.b);
            end
            if (stall !== e.s) begin
                n_bad++; $display("FAIL %s stall got %b exp %b", e.tag, stall, e.s);
            end
            if (rd_addr_a !== e.aa) begin
                n_bad++; $display("FAIL %s rd_addr_a got %0d exp %0d", e.tag, rd_addr_a, e.aa);
            end
            if (rd_addr_b !== e.ab) begin
                n_bad++; $display("FAIL %s rd_addr_b got %0d exp %0d", e.tag, rd_addr_b, e.ab);
            end
        end
    end

    initial begin
        quiet();
        instr = 32'h0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;

        // R3: idle state, add r0,r0,r0 with file values present
        expect_out("R3 idle", 32'h0, 32'h0, 1'b0, 4'd0, 4'd0);

        // R1 R9: plain add, no producers
        instr = mk(4'h0, 4'd5, 4'd3, 4'd7);
        expect_out("R1 R9 add fields", FA, FB, 1'b0, 4'd3, 4'd7);

        // R1: store takes port B from the high field
        instr = mk(4'h4, 4'd9, 4'd2, 4'd1);
        expect_out("R1 store fields", FA, FB, 1'b0, 4'd2, 4'd9);

        // R2: execute bypass on port A
        instr = mk(4'h0, 4'd1, 4'd3, 4'd7);
        ex_dst = 4'd3; ex_wen = 1'b1; ex_val = 32'h0000_0011;
        expect_out("R2 ex bypass", 32'h0000_0011, FB, 1'b0, 4'd3, 4'd7);

        // R4: all three stages write r7
        quiet();
        instr = mk(4'h0, 4'd1, 4'd2, 4'd7);
        ex_dst = 4'd7; ex_wen = 1; mem_dst = 4'd7; mem_wen = 1; wb_dst = 4'd7; wb_wen = 1;
        expect_out("R4 ex over mem/wb", FA, 32'hE0E0_0001, 1'b0, 4'd2, 4'd7);
        ex_wen = 0;
        expect_out("R4 mem over wb", FA, 32'h3E30_0002, 1'b0, 4'd2, 4'd7);
        mem_wen = 0;
        expect_out("R4 wb only", FA, 32'h7B70_0003, 1'b0, 4'd2, 4'd7);

        // R5: execute matches but does not write
        quiet();
        instr = mk(4'h0, 4'd1, 4'd3, 4'd7);
        ex_dst = 4'd3; mem_dst = 4'd3; mem_wen = 1; wb_dst = 4'd7;
        expect_out("R5 write-valid clear", 32'h3E30_0002, FB, 1'b0, 4'd3, 4'd7);

        // R3: every stage targets r0, load in execute
        quiet();
        instr = mk(4'h0, 4'd1, 4'd0, 4'd0);
        rf_val_a = 32'hDEAD_0000; rf_val_b = 32'hBEEF_0000;
        ex_wen = 1; ex_is_load = 1; mem_wen = 1; wb_wen = 1;
        expect_out("R3 register 0", 32'h0, 32'h0, 1'b0, 4'd0, 4'd0);

        // R6 R7: stall and bypass in the same cycle
        quiet();
        instr = mk(4'h0, 4'd1, 4'd3, 4'd7);
        ex_dst = 4'd3; ex_wen = 1; ex_is_load = 1;
        mem_dst = 4'd3; mem_wen = 1; wb_dst = 4'd7; wb_wen = 1;
        expect_out("R6 R7 stall with bypass", 32'h3E30_0002, 32'h7B70_0003, 1'b1, 4'd3, 4'd7);

        // R6: load only, file value kept
        mem_wen = 0; wb_wen = 0;
        expect_out("R6 load not bypassed", FA, FB, 1'b1, 4'd3, 4'd7);

        // R7: load, jump-and-link, store, skip consume the loaded register
        quiet();
        ex_dst = 4'd6; ex_wen = 1; ex_is_load = 1;
        instr = mk(4'h3, 4'd4, 4'd6, 4'd0);
        expect_out("R7 load base", FA, 32'h0, 1'b1, 4'd6, 4'd0);
        instr = mk(4'h6, 4'd15, 4'd6, 4'd0);
        expect_out("R7 jump-and-link", FA, 32'h0, 1'b1, 4'd6, 4'd0);
        instr = mk(4'h4, 4'd6, 4'd2, 4'd0);
        expect_out("R7 store data", FA, FB, 1'b1, 4'd2, 4'd6);
        instr = mk(4'h8, 4'd0, 4'd2, 4'd6);
        expect_out("R7 skip port B", FA, FB, 1'b1, 4'd2, 4'd6);

        // R8: unconsumed fields never stall
        instr = mk(4'h2, 4'd1, 4'd2, 4'd6);
        expect_out("R8 add-immediate low field", FA, FB, 1'b0, 4'd2, 4'd6);
        instr = mk(4'h5, 4'd0, 4'd6, 4'd6);
        expect_out("R8 goto", FA, FB, 1'b0, 4'd6, 4'd6);
        instr = mk(4'h7, 4'd6, 4'd6, 4'd6);
        expect_out("R8 halt", FA, FB, 1'b0, 4'd6, 4'd6);
        instr = mk(4'h9, 4'd6, 4'd6, 4'd6);
        expect_out("R8 load address", FA, FB, 1'b0, 4'd6, 4'd6);

        // R2 R7: non-load producer of the jump target bypasses without stall
        ex_is_load = 0;
        instr = mk(4'h6, 4'd15, 4'd6, 4'd0);
        expect_out("R2 R7 non-load no stall", 32'hE0E0_0001, 32'h0, 1'b0, 4'd6, 4'd0);

        @(posedge clk);
        done = 1'b1;
        if (!summed) begin
            summed = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done && !summed) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired got hang exp completion");
            summed = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule